// File: doc/BRIEF.md
# Consecutive-Cycle Fault Qualifier

This block sits between the analog protection comparators of an off-line switching converter and its shutdown logic. It watches two comparator flags once per switching cycle and decides whether a trip is a real fault or a single noisy event. An output over-voltage flag counts only when it is seen inside a short strobe window that opens a fixed delay after the power switch turns off. A second-level over-current flag counts only while the gate is on.

Every switching cycle ends with a one-clock cycle-start strobe. At that boundary the block looks at what the finished cycle saw. Over-voltage has to appear in a configurable number of back-to-back cycles, four by default, before the fault output rises. The over-current path raises a warning after the first trip. If the next cycle trips again, it sets a shutdown latch. If the next cycle is clean, it drops back to idle. Both fault outputs hold until the supply-undervoltage flag is seen. A cycle in which the gate never switched, such as a burst-mode gap, leaves all qualification state as it was.

Top module: `cyc_fault_qual`

## Requirements
- R1: After reset, `ovp_fault`, `ocp_latched` and `ocp_warn` are all low.
- R2: `ov_cmp` counts only in the strobe window. The window covers off-time clocks STROBE_DELAY_CLKS to STROBE_DELAY_CLKS+STROBE_LEN_CLKS-1, counted from 0 at the first clock with the gate low after a gate pulse. An over-voltage level outside this window leaves the outputs unchanged.
- R3: `ovp_fault` rises at the cycle-start boundary that closes the OVP_CONFIRM-th consecutive gated cycle with an in-window over-voltage (default 4), and not earlier.
- R4: A gated cycle whose strobe window sees no over-voltage returns the over-voltage count to zero.
- R5: Once set, `ovp_fault` stays high whatever later cycles show, until `uv_off` is high for a clock. That clears it on the next edge.
- R6: The first gated cycle with `oc_cmp` high during the on-time sets `ocp_warn` and leaves `ocp_latched` low.
- R7: From the warning state, a gated cycle without an on-time over-current trip clears `ocp_warn` and returns the logic to idle.
- R8: OCP_CONFIRM consecutive gated cycles with on-time trips (default 2) set `ocp_latched` and clear `ocp_warn`.
- R9: `ocp_latched` holds through any later cycles and is cleared only by `uv_off`. `uv_off` also clears `ocp_warn` and both counts.
- R10: A cycle with no gate pulse neither advances nor clears either qualification count. Outputs change only at a cycle-start boundary or after `uv_off`.
- R11: `oc_cmp` high while the gate is off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that closes the current switching cycle and opens the next |
| gate_on | input | 1 | Power-switch gate state, high while on |
| ov_cmp | input | 1 | Output over-voltage comparator flag |
| oc_cmp | input | 1 | Second-level over-current comparator flag |
| uv_off | input | 1 | Supply below its undervoltage-off threshold |
| ovp_fault | output | 1 | Confirmed over-voltage fault |
| ocp_latched | output | 1 | Over-current shutdown latch |
| ocp_warn | output | 1 | Over-current warning state |

## Verification
Over-voltage pulses are placed both inside the strobe window and well before and after it. This separates correct window timing from plain level detection. Runs of three hits, a miss and three more hits separate a consecutive-cycle counter from a cumulative one. Inserting gate-less cycles that carry both comparator flags shows whether skipped cycles are really neutral rather than treated as misses or hits. Over-current trips placed in the on-time and in the off-time, followed by clean, tripping and gate-less cycles, walk the idle, warning and latched states through every exit, including release by undervoltage.

// File: rtl/cfq_pkg.sv
package cfq_pkg;

  typedef enum logic [1:0] {
    OC_IDLE = 2'd0,
    OC_WARN = 2'd1,
    OC_SHUT = 2'd2
  } oc_state_e;

  // What one closed switching cycle observed
  typedef struct packed {
    logic pulsed;   // gate was on at least one clock
    logic ov_hit;   // over-voltage seen inside the strobe window
    logic oc_hit;   // over-current seen during on-time
  } cyc_summary_t;

endpackage

// File: rtl/cfq_strobe_win.sv
module cfq_strobe_win #(
  parameter int DELAY_CLKS = 200,
  parameter int LEN_CLKS   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_on,
  output logic strobe
);
  localparam int SPAN = DELAY_CLKS + LEN_CLKS;
  localparam int CW   = $clog2(SPAN + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] WIN_LO  = CW'(DELAY_CLKS);
  localparam logic [CW-1:0] WIN_HI  = CW'(SPAN);

  logic [CW-1:0] off_cnt_q, off_cnt_d;
  logic          cnt_en;

  // off-time clock counter, parked at its maximum when idle
  assign cnt_en = gate_on || (off_cnt_q != CNT_MAX);

  always_comb begin
    off_cnt_d = off_cnt_q;
    if (gate_on)     off_cnt_d = '0;
    else if (cnt_en) off_cnt_d = off_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_cnt_q <= CNT_MAX;
    else if (cnt_en) off_cnt_q <= off_cnt_d;
  end

  assign strobe = !gate_on && (off_cnt_q >= WIN_LO) && (off_cnt_q < WIN_HI);
endmodule

// File: rtl/cfq_cycle_tracker.sv
module cfq_cycle_tracker
  import cfq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_start,
  input  logic         gate_on,
  input  logic         strobe,
  input  logic         ov_cmp,
  input  logic         oc_cmp,
  output logic         cyc_done,
  output cyc_summary_t summary
);
  cyc_summary_t acc_q, acc_d, seen;

  always_comb begin
    seen.pulsed = gate_on;
    seen.ov_hit = strobe && ov_cmp;
    seen.oc_hit = gate_on && oc_cmp;
    if (cyc_start) acc_d = '0;
    else           acc_d = acc_q | seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign cyc_done = cyc_start;
  assign summary  = acc_q;
endmodule

// File: rtl/cfq_ovp_qual.sv
module cfq_ovp_qual
  import cfq_pkg::*;
#(
  parameter int CONFIRM = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_done,
  input  cyc_summary_t summary,
  input  logic         uv_off,
  output logic         fault
);
  localparam int CW = $clog2(CONFIRM + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(CONFIRM);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault_q, fault_d;
  logic          upd_en;

  assign upd_en = uv_off || (cyc_done && summary.pulsed);

  always_comb begin
    cnt_d   = cnt_q;
    fault_d = fault_q;
    if (uv_off) begin
      cnt_d   = '0;
      fault_d = 1'b0;
    end else if (summary.ov_hit) begin
      if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
      fault_d = fault_q || (cnt_d == CNT_TOP);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/cfq_ocp_qual.sv
module cfq_ocp_qual
  import cfq_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_done,
  input  cyc_summary_t summary,
  input  logic         uv_off,
  output logic         warn,
  output logic         latched
);
  localparam int CW = $clog2(CONFIRM + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(CONFIRM);

  oc_state_e     st_q, st_d;
  logic [CW-1:0] trip_q, trip_d;
  logic          upd_en;

  assign upd_en = uv_off || (cyc_done && summary.pulsed);

  always_comb begin
    st_d   = st_q;
    trip_d = trip_q;
    if (uv_off) begin
      st_d   = OC_IDLE;
      trip_d = '0;
    end else begin
      unique case (st_q)
        OC_IDLE, OC_WARN: begin
          if (summary.oc_hit) begin
            trip_d = trip_q + 1'b1;
            st_d   = (trip_d >= CNT_TOP) ? OC_SHUT : OC_WARN;
          end else begin
            trip_d = '0;
            st_d   = OC_IDLE;
          end
        end
        OC_SHUT: st_d = OC_SHUT;
        default: begin
          st_d   = OC_IDLE;
          trip_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OC_IDLE;
      trip_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      trip_q <= trip_d;
    end
  end

  assign warn    = (st_q == OC_WARN);
  assign latched = (st_q == OC_SHUT);
endmodule

// File: rtl/cyc_fault_qual.sv
module cyc_fault_qual
  import cfq_pkg::*;
#(
  parameter int STROBE_DELAY_CLKS = 200,
  parameter int STROBE_LEN_CLKS   = 50,
  parameter int OVP_CONFIRM       = 4,
  parameter int OCP_CONFIRM       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic gate_on,
  input  logic ov_cmp,
  input  logic oc_cmp,
  input  logic uv_off,
  output logic ovp_fault,
  output logic ocp_latched,
  output logic ocp_warn
);
  logic         strobe;
  logic         cyc_done;
  cyc_summary_t summary;

  cfq_strobe_win #(
    .DELAY_CLKS(STROBE_DELAY_CLKS),
    .LEN_CLKS  (STROBE_LEN_CLKS)
  ) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_on(gate_on),
    .strobe (strobe)
  );

  cfq_cycle_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .gate_on  (gate_on),
    .strobe   (strobe),
    .ov_cmp   (ov_cmp),
    .oc_cmp   (oc_cmp),
    .cyc_done (cyc_done),
    .summary  (summary)
  );

  cfq_ovp_qual #(.CONFIRM(OVP_CONFIRM)) u_ovp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_done(cyc_done),
    .summary (summary),
    .uv_off  (uv_off),
    .fault   (ovp_fault)
  );

  cfq_ocp_qual #(.CONFIRM(OCP_CONFIRM)) u_ocp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_done(cyc_done),
    .summary (summary),
    .uv_off  (uv_off),
    .warn    (ocp_warn),
    .latched (ocp_latched)
  );
endmodule

// File: rtl/cfq_checker.sv
module cfq_checker (
  input logic clk,
  input logic rst_n,
  input logic cyc_start,
  input logic uv_off,
  input logic ovp_fault,
  input logic ocp_latched,
  input logic ocp_warn
);
  // R8: warning and shutdown are exclusive
  p_warn_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ocp_latched && ocp_warn));

  // R8: shutdown is only reached through the warning state
  p_shut_via_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_latched) |-> $past(ocp_warn));

  // R9: latch holds while the supply stays up
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_latched && !uv_off) |=> ocp_latched);

  // R5: over-voltage fault holds while the supply stays up
  p_ovp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_fault && !uv_off) |=> ovp_fault);

  // R5, R9: undervoltage clears both faults and the warning
  p_uv_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_off |=> (!ovp_fault && !ocp_latched && !ocp_warn));

  // R10: outputs move only at a cycle boundary or on undervoltage
  p_quiet_midcycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && !uv_off) |=> ($stable(ovp_fault) && $stable(ocp_latched) && $stable(ocp_warn)));
endmodule

bind cyc_fault_qual cfq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_start  (cyc_start),
  .uv_off     (uv_off),
  .ovp_fault  (ovp_fault),
  .ocp_latched(ocp_latched),
  .ocp_warn   (ocp_warn)
);

// File: tb/cyc_fault_qual_tb_top.sv
`timescale 1ns/1ps
module cyc_fault_qual_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic cyc_start, gate_on, ov_cmp, oc_cmp, uv_off;
  logic ovp_fault, ocp_latched, ocp_warn;

  always #5 clk = ~clk;

  cyc_fault_qual dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .gate_on(gate_on),
    .ov_cmp(ov_cmp), .oc_cmp(oc_cmp), .uv_off(uv_off),
    .ovp_fault(ovp_fault), .ocp_latched(ocp_latched), .ocp_warn(ocp_warn)
  );

  // scoreboard
  logic [2:0] exp_q[$];
  string      tag_q[$];
  event       mon_ev;
  int         n_checks = 0;
  int         n_fails  = 0;
  bit         done     = 1'b0;

  // reference model state, from the requirements
  int m_ovcnt = 0;
  bit m_ovp = 0, m_warn = 0, m_lat = 0;
  int m_trips = 0;

  task automatic push_exp(input string tag);
    exp_q.push_back({m_ovp, m_lat, m_warn});
    tag_q.push_back(tag);
    -> mon_ev;
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if ({ovp_fault, ocp_latched, ocp_warn} !== e) begin
          n_fails++;
          $display("FAIL %s: {ovp,latched,warn} actual=%b expected=%b", t,
                   {ovp_fault, ocp_latched, ocp_warn}, e);
        end
      end
    end
  end

  // ocm: 0 none, 1 during on-time, 2 during off-time
  // ovm: 0 none, 1 inside strobe window, 2 outside window only
  task automatic run_cycle(input bit pulse, input int ocm, input int ovm, input string tag);
    for (int i = 0; i < 320; i++) begin
      @(negedge clk);
      gate_on = pulse && (i < 20);
      oc_cmp  = (ocm == 1 && i >= 5 && i < 10) || (ocm == 2 && i >= 40 && i < 200);
      ov_cmp  = (ovm == 1 && i >= 230 && i < 240) ||
                (ovm == 2 && ((i >= 60 && i < 200) || (i >= 280 && i < 310)));
    end
    @(negedge clk);
    gate_on = 0; oc_cmp = 0; ov_cmp = 0; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    if (pulse) begin
      if (ovm == 1) begin
        if (m_ovcnt < 4) m_ovcnt++;
        if (m_ovcnt == 4) m_ovp = 1;
      end else m_ovcnt = 0;
      if (!m_lat) begin
        if (ocm == 1) begin
          m_trips++;
          if (m_trips >= 2) begin m_lat = 1; m_warn = 0; end
          else m_warn = 1;
        end else begin
          m_trips = 0; m_warn = 0;
        end
      end
    end
    push_exp(tag);
  endtask

  task automatic pulse_uv(input string tag);
    @(negedge clk); uv_off = 1;
    @(negedge clk); uv_off = 0;
    m_ovcnt = 0; m_ovp = 0; m_warn = 0; m_lat = 0; m_trips = 0;
    push_exp(tag);
  endtask

  initial begin
    rst_n = 0; cyc_start = 0; gate_on = 0; ov_cmp = 0; oc_cmp = 0; uv_off = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push_exp("R1 reset state");

    // R2: over-voltage outside the strobe window is ignored
    for (int k = 0; k < 5; k++) run_cycle(1, 0, 2, "R2 out-of-window ov");

    // R3: fault only after the fourth consecutive hit
    for (int k = 0; k < 4; k++) run_cycle(1, 0, 1, "R3 consecutive ov");
    // R5: sticky until undervoltage
    run_cycle(1, 0, 0, "R5 ovp holds on clean cycle");
    run_cycle(0, 0, 0, "R5 ovp holds on idle cycle");
    pulse_uv("R5 uv clears ovp");

    // R4: a miss restarts the count
    for (int k = 0; k < 3; k++) run_cycle(1, 0, 1, "R4 three hits");
    run_cycle(1, 0, 0, "R4 miss");
    for (int k = 0; k < 3; k++) run_cycle(1, 0, 1, "R4 three hits after miss");
    run_cycle(1, 0, 1, "R4 fourth hit after miss");
    pulse_uv("R5 uv clears");

    // R10: gate-less cycle is neutral for the ov count
    run_cycle(1, 0, 1, "R10 hit1");
    run_cycle(1, 0, 1, "R10 hit2");
    run_cycle(0, 1, 1, "R10 no-gate cycle");
    run_cycle(1, 0, 1, "R10 hit3");
    run_cycle(1, 0, 1, "R10 hit4 confirms");
    pulse_uv("R9 uv clear");

    // R6 / R7: warning then back to idle
    run_cycle(1, 1, 0, "R6 first trip warns");
    run_cycle(1, 0, 0, "R7 clean cycle returns idle");
    // R11: off-time over-current ignored
    run_cycle(1, 1, 0, "R6 trip again");
    run_cycle(1, 2, 0, "R11 off-time oc ignored");
    run_cycle(1, 2, 0, "R11 off-time oc from idle ignored");
    // R8: two consecutive trips latch
    run_cycle(1, 1, 0, "R6 warn");
    run_cycle(1, 1, 0, "R8 second trip latches");
    // R9: latch held
    run_cycle(1, 0, 0, "R9 latch holds on clean cycle");
    run_cycle(1, 1, 0, "R9 latch holds on trip cycle");
    pulse_uv("R9 uv clears latch");

    // R10: gate-less cycle is neutral for the oc state
    run_cycle(1, 1, 0, "R10 oc warn");
    run_cycle(0, 1, 0, "R10 no-gate keeps warn");
    run_cycle(1, 1, 0, "R10 trip after gap latches");
    pulse_uv("R9 final uv");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule